// File: doc/BRIEF.md
# Hypervisor Decrementer Interval Timer

This block is a signed down-counter that gives hypervisor software a programmable delay followed by a timer exception. The counter steps down by one on a divided tick pulse, not on every core clock. The block generates that pulse itself and drives it out so that the time-base counter elsewhere advances on exactly the same enables. Because both counters share one tick, they stay coherent.

Software loads the counter through a write port and samples it through a read port. A sample has no effect on the count or on the exception. The exception output is a level that follows the sign bit of the count. It rises when the count turns negative. It is withdrawn after the count turns non-negative again, no later than the next synchronization pulse. This rule is the same whether the count changed through a tick or through a write. An acknowledge input can also drop the level, but any new flip to negative raises it again.

Top module: `hv_dec_timer`

## Requirements
- R1: After reset the count holds 0x7FFF_FFFF, `exc_o` and `tick_o` are low, and `rd_data` is zero.
- R2: `tick_o` is high for one cycle out of every `TICK_DIV` cycles. It is first high in the cycle that follows the `TICK_DIV-1`th rising edge after reset is released.
- R3: The count is 32 bits, two's complement. At the edge that closes a cycle with `tick_o` high, it decreases by one modulo 2^32. Without a tick or a write, it holds its value.
- R4: At the edge that closes a cycle with `wr_en` high, the count takes `wr_data` in full. When a write and a tick share a cycle, the write wins and that tick is lost.
- R5: When bit 31 of the count goes from 0 to 1, `exc_o` is high from that same edge on. This holds whether the change came from a tick or from a write.
- R6: With `CLR_AT_SYNC`=1, `exc_o` drops at the edge that closes a cycle where `sync_event` is high and bit 31 of the current count is 0. A `sync_event` while bit 31 is 1 leaves `exc_o` high. With `CLR_AT_SYNC`=0, `exc_o` drops at the edge where bit 31 goes from 1 to 0.
- R7: `ack` drops `exc_o` at the next edge. If that same edge carries a 0-to-1 flip of bit 31, the set wins and `exc_o` stays high.
- R8: At the edge that closes a cycle with `rd_en` high, `rd_data` captures the count as it stood before that edge, and then holds. Reads change neither the count nor `exc_o`.
- R9: After an acknowledge, a count that keeps decrementing while negative does not raise `exc_o` again.
- R10: Decrementing 0x8000_0000 gives 0x7FFF_FFFF. This counts as a 1-to-0 flip of bit 31 and follows the withdrawal rule of R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Load the count from `wr_data` |
| wr_data | input | CNT_W | Value to load |
| rd_en | input | 1 | Capture the count into `rd_data` |
| rd_data | output | CNT_W | Last captured count |
| ack | input | 1 | Drop the exception level |
| sync_event | input | 1 | Synchronization pulse that completes a pending withdrawal |
| tick_o | output | 1 | Divided tick, shared with the time base |
| exc_o | output | 1 | Hypervisor decrementer exception level |

## Verification
The clocked properties assume that `wr_en`, `ack`, `sync_event` and `rd_en` are plain single-cycle or multi-cycle levels that hold steady across each sampling edge. No other assumption on the inputs is needed. The withdrawal and acknowledge properties admit a coincident sign flip as an explicit exception, so a write or tick in the same cycle as `ack` or `sync_event` stays legal. The bench changes every input on the falling clock edge. It shrinks the tick divisor so that a full sign-flip cycle fits in a few dozen clocks. It deliberately places writes, acknowledges and sync pulses on and beside tick cycles.

// File: rtl/hvdec_pkg.sv
package hvdec_pkg;

  typedef enum logic [1:0] {
    FLIP_NONE = 2'd0,
    FLIP_UP   = 2'd1,
    FLIP_DOWN = 2'd2
  } sign_flip_e;

  function automatic sign_flip_e sign_flip(input logic old_msb, input logic new_msb);
    if (!old_msb && new_msb)      return FLIP_UP;
    else if (old_msb && !new_msb) return FLIP_DOWN;
    else                          return FLIP_NONE;
  endfunction

endpackage

// File: rtl/hvdec_tick_gen.sv
module hvdec_tick_gen #(
  parameter int TICK_DIV = 32
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  generate
    if (TICK_DIV <= 1) begin : g_every
      logic run_q;
      always_ff @(posedge clk) begin
        if (!rst_n) run_q <= 1'b0;
        else        run_q <= 1'b1;
      end
      assign tick = run_q;
    end else begin : g_div
      localparam int DIV_W = $clog2(TICK_DIV);
      localparam logic [DIV_W-1:0] LAST = DIV_W'(TICK_DIV - 1);
      logic [DIV_W-1:0] div_q;
      always_ff @(posedge clk) begin
        if (!rst_n)            div_q <= '0;
        else if (div_q == LAST) div_q <= '0;
        else                   div_q <= div_q + DIV_W'(1);
      end
      assign tick = (div_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/hvdec_counter.sv
module hvdec_counter #(
  parameter int CNT_W = 32,
  parameter logic [CNT_W-1:0] RST_VAL = {1'b0, {(CNT_W-1){1'b1}}}
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_d
);
  function automatic logic [CNT_W-1:0] step_down(input logic [CNT_W-1:0] v);
    return v - CNT_W'(1);
  endfunction

  always_comb begin
    if (wr_en)     cnt_d = wr_data;
    else if (tick) cnt_d = step_down(cnt_q);
    else           cnt_d = cnt_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= RST_VAL;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/hvdec_exc_ctrl.sv
module hvdec_exc_ctrl
  import hvdec_pkg::*;
#(
  parameter bit CLR_AT_SYNC = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cur_msb,
  input  logic nxt_msb,
  input  logic ack,
  input  logic sync_event,
  output logic exc,
  output logic set_evt,
  output logic drop_evt
);
  sign_flip_e flip;
  assign flip    = sign_flip(cur_msb, nxt_msb);
  assign set_evt = (flip == FLIP_UP);

  generate
    if (CLR_AT_SYNC) begin : g_sync_clr
      assign drop_evt = sync_event && !cur_msb;
    end else begin : g_fast_clr
      assign drop_evt = (flip == FLIP_DOWN);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)                exc <= 1'b0;
    else if (set_evt)          exc <= 1'b1;
    else if (ack || drop_evt)  exc <= 1'b0;
  end
endmodule

// File: rtl/hv_dec_timer.sv
module hv_dec_timer #(
  parameter int CNT_W       = 32,
  parameter int TICK_DIV    = 32,
  parameter bit CLR_AT_SYNC = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             rd_en,
  output logic [CNT_W-1:0] rd_data,
  input  logic             ack,
  input  logic             sync_event,
  output logic             tick_o,
  output logic             exc_o
);
  localparam int MSB = CNT_W - 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             set_evt;
  logic             drop_evt;

  hvdec_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick_o)
  );

  hvdec_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick_o), .wr_en(wr_en),
    .wr_data(wr_data), .cnt_q(cnt_q), .cnt_d(cnt_d)
  );

  hvdec_exc_ctrl #(.CLR_AT_SYNC(CLR_AT_SYNC)) u_exc (
    .clk(clk), .rst_n(rst_n), .cur_msb(cnt_q[MSB]), .nxt_msb(cnt_d[MSB]),
    .ack(ack), .sync_event(sync_event), .exc(exc_o),
    .set_evt(set_evt), .drop_evt(drop_evt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= cnt_q;
  end
endmodule

// File: rtl/hvdec_chk.sv
module hvdec_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_o,
  input logic             wr_en,
  input logic [CNT_W-1:0] wr_data,
  input logic             rd_en,
  input logic [CNT_W-1:0] rd_data,
  input logic             ack,
  input logic             sync_event,
  input logic [CNT_W-1:0] cnt,
  input logic             exc_o
);
  localparam int MSB = CNT_W - 1;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_o && !wr_en) |=> $stable(cnt)); // R3
  AST_TICK_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && !wr_en) |=> (cnt == $past(cnt) - ONE)); // R3
  AST_WRITE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (cnt == $past(wr_data))); // R4
  AST_SET_ON_NEG: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt[MSB]) |=> (cnt[MSB] -> exc_o)); // R5
  AST_SYNC_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_event && !cnt[MSB]) |=> (!exc_o || cnt[MSB])); // R6
  AST_ACK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && cnt[MSB]) |=> !exc_o); // R7
  AST_READ_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> (rd_data == $past(cnt))); // R8
  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (!exc_o && cnt[MSB]) |=> !exc_o); // R9
endmodule

bind hv_dec_timer hvdec_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_o(tick_o), .wr_en(wr_en), .wr_data(wr_data),
  .rd_en(rd_en), .rd_data(rd_data), .ack(ack), .sync_event(sync_event),
  .cnt(cnt_q), .exc_o(exc_o)
);

// File: tb/sim_hv_dec_timer.sv
`timescale 1ns/1ps
module sim_hv_dec_timer;
  localparam int DIV = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [31:0] rd_data;
  logic        ack = 1'b0;
  logic        sync_event = 1'b0;
  logic        tick_o;
  logic        exc_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  hv_dec_timer #(.CNT_W(32), .TICK_DIV(DIV), .CLR_AT_SYNC(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_data), .ack(ack), .sync_event(sync_event), .tick_o(tick_o), .exc_o(exc_o)
  );

  // Reference state, derived from the requirements.
  int          k;
  logic [31:0] m_cnt, m_rd, nxt;
  logic        m_exc;
  always @(posedge clk) begin
    if (!rst_n) begin
      k = 0; m_cnt = 32'h7FFF_FFFF; m_exc = 1'b0; m_rd = '0;
    end else begin
      k = k + 1;
      if (wr_en)             nxt = wr_data;
      else if (k % DIV == 0) nxt = m_cnt - 32'd1;
      else                   nxt = m_cnt;
      if (rd_en) m_rd = m_cnt;
      if (!m_cnt[31] && nxt[31])                 m_exc = 1'b1;
      else if (ack || (sync_event && !m_cnt[31])) m_exc = 1'b0;
      m_cnt = nxt;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic write(input logic [31:0] v);
    wr_en = 1'b1; wr_data = v; @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic read_check(input string req);
    rd_en = 1'b1; @(negedge clk); rd_en = 1'b0;
    check(req, rd_data, m_rd);
  endtask

  task automatic wait_tick();
    while (tick_o !== 1'b1) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 exc", {31'd0, exc_o}, 32'd0);
    check("R1 tick", {31'd0, tick_o}, 32'd0);
    check("R1 rd_data", rd_data, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    rd_en = 1'b1; @(negedge clk); rd_en = 1'b0;
    check("R1 count", rd_data, 32'h7FFF_FFFF);
  endtask

  task automatic t_tick();
    for (int i = 0; i < 3 * DIV; i++) begin
      check("R2 tick", {31'd0, tick_o}, {31'd0, (k % DIV == DIV - 1)});
      @(negedge clk);
    end
  endtask

  task automatic t_decrement();
    write(32'd100);
    cyc(3 * DIV + 1);
    read_check("R3 decrement");
    check("R3 range", {31'd0, (rd_data < 32'd100 && rd_data >= 32'd95)}, 32'd1);
  endtask

  task automatic t_write_vs_tick();
    wait_tick();
    write(32'h0000_1234);
    rd_en = 1'b1; @(negedge clk); rd_en = 1'b0;
    check("R4 write wins", rd_data, 32'h0000_1234);
  endtask

  task automatic t_set_by_tick();
    write(32'd1);
    cyc(2 * DIV + 1);
    check("R5 set by tick", {31'd0, exc_o}, 32'd1);
    check("R5 model", {31'd0, exc_o}, {31'd0, m_exc});
  endtask

  task automatic t_ack();
    ack = 1'b1; @(negedge clk); ack = 1'b0;
    check("R7 ack drop", {31'd0, exc_o}, 32'd0);
    cyc(3 * DIV);
    check("R9 stays low", {31'd0, exc_o}, 32'd0);
    read_check("R9 still negative");
  endtask

  task automatic t_set_over_ack();
    write(32'd10);
    wr_en = 1'b1; wr_data = 32'hFFFF_0000; ack = 1'b1;
    @(negedge clk); wr_en = 1'b0; ack = 1'b0;
    check("R7 set beats ack", {31'd0, exc_o}, 32'd1);
    check("R5 set by write", {31'd0, exc_o}, 32'd1);
  endtask

  task automatic t_sync();
    sync_event = 1'b1; @(negedge clk); sync_event = 1'b0;
    check("R6 sync while negative", {31'd0, exc_o}, 32'd1);
    write(32'd1000);
    cyc(3);
    check("R6 pending withdrawal", {31'd0, exc_o}, 32'd1);
    sync_event = 1'b1; @(negedge clk); sync_event = 1'b0;
    check("R6 sync drop", {31'd0, exc_o}, 32'd0);
  endtask

  task automatic t_wrap();
    write(32'd3);
    write(32'h8000_0001);
    check("R10 set", {31'd0, exc_o}, 32'd1);
    cyc(3 * DIV);
    read_check("R10 wrap value");
    check("R10 positive", {31'd0, rd_data[31]}, 32'd0);
    check("R10 held until sync", {31'd0, exc_o}, 32'd1);
    sync_event = 1'b1; @(negedge clk); sync_event = 1'b0;
    check("R10 dropped at sync", {31'd0, exc_o}, 32'd0);
  endtask

  task automatic t_read_noeffect();
    write(32'd5);
    write(32'hFFFF_FFF0);
    for (int i = 0; i < 2 * DIV; i++) begin
      rd_en = 1'b1; @(negedge clk);
      check("R8 read value", rd_data, m_rd);
      check("R8 exc kept", {31'd0, exc_o}, 32'd1);
    end
    rd_en = 1'b0;
    read_check("R8 count after reads");
  endtask

  initial begin
    cyc(3);
    t_reset();
    t_tick();
    t_decrement();
    t_write_vs_tick();
    t_set_by_tick();
    t_ack();
    t_set_over_ack();
    t_sync();
    t_wrap();
    t_read_noeffect();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule